// File: doc/BRIEF.md
# Transition-Filtered Status Register Group

This block watches a vector of live status lines and turns selected changes on them into sticky event flags. Each line has its own pair of programmable filters. One filter qualifies a low-to-high change and the other qualifies a high-to-low change. A qualifying change sets the matching bit of an event register. That bit stays set until software reads the event register, and the read clears the whole register.

An enable mask selects which event bits count toward a single summary output. Higher-level status logic uses that output as one bit of its summary byte.

Software reaches the group through a simple single-cycle register bus:
- The live condition, the event register and read data are presented combinationally while a read request is held.
- Writes take effect at the clock edge.
- The event register is cleared at the clock edge that ends a read of it.

Top module: `status_xfilt_group`

## Requirements
- R1: A read at address 0 (condition) returns the live value of `status_i` in the same cycle. Writes to address 0 change nothing.
- R2: When a status bit changes from 0 to 1 between two consecutive clock edges and its bit in the rising filter (address 1) is set, the matching event bit reads as 1 from the following cycle onward.
- R3: When a status bit changes from 1 to 0 and its bit in the falling filter (address 2) is set, the matching event bit is set in the same way.
- R4: A position with both filter bits clear never sets its event bit. A position with both filter bits set captures either direction of change.
- R5: Event bits (address 3) stay set across any number of cycles without a read of address 3. A read of address 3 returns the current event bits and clears all of them at the end of that cycle.
- R6: A qualifying change detected in the same cycle as a read of address 3 is not lost: its event bit is set after the clear, and it is not included in the data of that read.
- R7: The rising filter (address 1), falling filter (address 2) and enable mask (address 4) are read/write and return the last value written.
- R8: `summary_o` is 1 exactly when at least one event bit is set whose enable bit is also set.
- R9: After reset every register reads zero and `summary_o` is 0. The previous-condition copy also resets to zero.
- R10: Writes to address 3 do not change the event register. Reads of the unmapped addresses 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | W | Live status lines, synchronous to clk_i |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register select (0 cond, 1 rise filter, 2 fall filter, 3 event, 4 enable) |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data, valid while a read request is held |
| summary_o | output | 1 | OR of enabled event bits |

## Verification
The hardest situation to create from the ports is a status edge that lands in the very cycle that clears the event register. In that cycle the old event bits must be returned, and only the new edge must survive. The bench builds this case directly: it changes `status_i` on the falling clock edge and holds an event read during the same cycle. It then reads the event register again to confirm that only the new bit remains. A long pseudo-random phase then mixes reads, writes and status flips, so the same collision also occurs many times with arbitrary filter and mask settings.

// File: rtl/sxf_pkg.sv
package sxf_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_COND = 3'd0,
    A_RISE = 3'd1,
    A_FALL = 3'd2,
    A_EVT  = 3'd3,
    A_ENA  = 3'd4
  } sxf_addr_e;
endpackage

// File: rtl/sxf_edge_filter.sv
module sxf_edge_filter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] cond_q_o,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= '0;
    else         cond_q <= cond_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic rose, fell;
    assign rose     = cond_i[b] & ~cond_q[b];
    assign fell     = ~cond_i[b] & cond_q[b];
    assign hit_o[b] = (rose & rise_en_i[b]) | (fell & fall_en_i[b]);
  end

  assign cond_q_o = cond_q;
endmodule

// File: rtl/sxf_event_latch.sv
module sxf_event_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] evt_q;

  // a set in the clear cycle wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    evt_q <= '0;
    else if (clr_i) evt_q <= set_i;
    else            evt_q <= evt_q | set_i;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/sxf_regfile.sv
module sxf_regfile
  import sxf_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rise_o,
  output logic [W-1:0]      fall_o,
  output logic [W-1:0]      ena_o
);
  localparam int unsigned NREG = 3;
  localparam logic [ADDR_W-1:0] REG_ADDR [NREG] = '{A_RISE, A_FALL, A_ENA};

  logic [W-1:0] reg_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            reg_q[i] <= '0;
      else if (wr_i && addr_i == REG_ADDR[i]) reg_q[i] <= wdata_i;
    end
  end

  assign rise_o = reg_q[0];
  assign fall_o = reg_q[1];
  assign ena_o  = reg_q[2];
endmodule

// File: rtl/status_xfilt_group.sv
module status_xfilt_group
  import sxf_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      status_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              summary_o
);
  logic [W-1:0] cond_q, rise_q, fall_q, ena_q, evt_q, hit;
  logic         rd, rd_evt;

  assign rd     = req_i & ~we_i;
  assign rd_evt = rd & (addr_i == A_EVT);

  sxf_regfile #(.W(W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (req_i & we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rise_o (rise_q),
    .fall_o (fall_q),
    .ena_o  (ena_q)
  );

  sxf_edge_filter #(.W(W)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cond_i   (status_i),
    .rise_en_i(rise_q),
    .fall_en_i(fall_q),
    .cond_q_o (cond_q),
    .hit_o    (hit)
  );

  sxf_event_latch #(.W(W)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hit),
    .clr_i (rd_evt),
    .evt_o (evt_q)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        A_COND:  rdata_o = status_i;
        A_RISE:  rdata_o = rise_q;
        A_FALL:  rdata_o = fall_q;
        A_EVT:   rdata_o = evt_q;
        A_ENA:   rdata_o = ena_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign summary_o = |(evt_q & ena_q);
endmodule

// File: rtl/sxf_checker.sv
module sxf_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] status_i,
  input logic [W-1:0] cond_q,
  input logic [W-1:0] rise_q,
  input logic [W-1:0] fall_q,
  input logic [W-1:0] evt_q,
  input logic [W-1:0] hit,
  input logic         rd_evt,
  input logic         rd_cond,
  input logic [W-1:0] rdata_o,
  input logic         summary_o
);
  AST_COND_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cond |-> rdata_o == status_i); // R1

  AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_i & ~cond_q & rise_q)) & ~evt_q) == '0); // R2

  AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(~status_i & cond_q & fall_q)) & ~evt_q) == '0); // R3

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_evt |=> (evt_q & $past(evt_q)) == $past(evt_q)); // R5

  AST_CLR_KEEPS_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt |=> evt_q == $past(hit)); // R6

  AST_SUMMARY_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    summary_o |-> evt_q != '0); // R8
endmodule

bind status_xfilt_group sxf_checker #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .status_i (status_i),
  .cond_q   (cond_q),
  .rise_q   (rise_q),
  .fall_q   (fall_q),
  .evt_q    (evt_q),
  .hit      (hit),
  .rd_evt   (rd_evt),
  .rd_cond  (rd && addr_i == sxf_pkg::A_COND),
  .rdata_o  (rdata_o),
  .summary_o(summary_o)
);

// File: tb/status_xfilt_group_test.sv
module status_xfilt_group_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [W-1:0] status_i;
  logic         req, we;
  logic [2:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;
  logic         summary;

  int n_run = 0, n_fail = 0;
  logic [W-1:0] m_prev, m_rise, m_fall, m_ena, m_evt;
  logic [15:0]  lfsr = 16'hACE1;

  always #5 clk = ~clk;

  status_xfilt_group #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .status_i(status_i), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .summary_o(summary)
  );

  function automatic logic [W-1:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return status_i;
      3'd1: return m_rise;
      3'd2: return m_fall;
      3'd3: return m_evt;
      3'd4: return m_ena;
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // entered at a falling edge; returns at the next falling edge
  task automatic cyc(bit r, bit w, logic [2:0] a, logic [W-1:0] d, string tag);
    logic [W-1:0] hits;
    req = r; we = w; addr = a; wdata = d;
    #1;
    if (r && !w) check(tag, rdata, m_read(a));
    check("R8 summary", W'(summary), W'(|(m_evt & m_ena)));
    @(posedge clk);
    hits = (status_i & ~m_prev & m_rise) | (~status_i & m_prev & m_fall);
    if (r && !w && a == 3'd3) m_evt = hits;
    else                      m_evt = m_evt | hits;
    if (r && w) begin
      if (a == 3'd1) m_rise = d;
      if (a == 3'd2) m_fall = d;
      if (a == 3'd4) m_ena  = d;
    end
    m_prev = status_i;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d); cyc(1, 1, a, d, "wr"); endtask
  task automatic rd(logic [2:0] a, string tag);      cyc(1, 0, a, '0, tag); endtask
  task automatic idle();                             cyc(0, 0, 3'd0, '0, "idle"); endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; status_i = '0; req = 0; we = 0; addr = '0; wdata = '0;
    m_prev = '0; m_rise = '0; m_fall = '0; m_ena = '0; m_evt = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R9 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R9 reset read");

    // R7 read/write registers
    wr(3'd1, 16'hA5C3); rd(3'd1, "R7 rise filter");
    wr(3'd2, 16'h3C5A); rd(3'd2, "R7 fall filter");
    wr(3'd4, 16'hFFFF); rd(3'd4, "R7 enable");
    // R1 condition write ignored, live read
    wr(3'd0, 16'hFFFF); rd(3'd0, "R1 cond after write");
    status_i = 16'h1234; rd(3'd0, "R1 cond live");
    status_i = '0; idle(); rd(3'd3, "R5 clear");
    // R10 event write ignored, unmapped reads zero
    wr(3'd3, 16'hFFFF); rd(3'd3, "R10 event write ignored");
    rd(3'd5, "R10 unmapped 5"); rd(3'd7, "R10 unmapped 7");

    // directed filter tests; bit 8 both filters, bit 2 neither
    wr(3'd1, 16'h01F1); wr(3'd2, 16'h0F02); wr(3'd4, 16'h0003);
    rd(3'd3, "R5 clear");
    status_i = 16'h0001; idle(); rd(3'd3, "R2 rise bit0");
    status_i = 16'h0000; idle(); rd(3'd3, "R4 fall bit0 unfiltered");
    status_i = 16'h0002; idle(); rd(3'd3, "R4 rise bit1 unfiltered");
    status_i = 16'h0000; idle(); idle(); idle(); rd(3'd3, "R3 fall bit1 sticky");
    status_i = 16'h0004; idle(); status_i = 16'h0000; idle(); rd(3'd3, "R4 neither bit2");
    status_i = 16'h0100; idle(); rd(3'd3, "R4 both rise bit8");
    status_i = 16'h0000; idle(); rd(3'd3, "R4 both fall bit8");
    // R8 summary masking: bit 4 event not enabled
    status_i = 16'h0010; idle(); idle(); check("R8 masked", W'(summary), '0);
    wr(3'd4, 16'h0010); idle(); check("R8 enabled", W'(summary), W'(1));
    rd(3'd3, "R5 read clears");
    // R6 edge in the same cycle as the clearing read
    status_i = 16'h0000; idle(); rd(3'd3, "R5 clear");
    status_i = 16'h0011; rd(3'd3, "R6 read during edge");
    rd(3'd3, "R6 new event survives");

    // pseudo-random mix
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) status_i = status_i ^ (16'h1 << lfsr[7:4]);
      case (lfsr[10:8])
        3'd0, 3'd1: rd(3'd3, "R6 random event read");
        3'd2:       wr(3'(1 + (lfsr[12:11] % 2)), {lfsr[3:0], lfsr[15:4]});
        3'd3:       wr(3'd4, lfsr ^ 16'h5A5A);
        3'd4:       rd(lfsr[13:11], "R7 random read");
        default:    idle();
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule